// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Pin Override

This block is the data register of a boundary-scan test port. It is a chain of scan cells placed between the core and the pads. Every cell has two stages. The first is a capture/shift flop clocked on the rising test clock. The second is an update flop clocked on the falling test clock. The test access controller and the instruction decoder sit outside this block. They supply the capture, shift and update strobes and three decoded selects: external test, sample/preload and float-all.

While the chain is selected (sample/preload or external test), a capture strobe snapshots the pad inputs and the core's outgoing values and enables. A shift strobe moves the chain one place toward the serial output. An update strobe copies the chain into the update stage on the falling edge. Under external test, the pads take their value and their drive enable from the update stage, not from the core. Under float-all, every drive enable is forced off. With neither select active, the pads follow the core unchanged, and the chain can be captured and shifted without disturbing operation.

The chain has `N_IN` input-only pins and `N_IO` bidirectional pins, so it is `N_IN + 3*N_IO` cells long. Counting from the serial input, cells 0 to `N_IN-1` observe `pin_in[0..N_IN-1]`. Each bidirectional pin j then owns three consecutive cells starting at `N_IN + 3*j`, in this order: enable cell, data cell, input cell.

Top module: `bscan_chain`

## Requirements
- R1: While `trst_n` is low, every capture/shift cell and every update cell is 0 and `tdo` is 0, so that a later external test with no update drives all enables low and all values 0.
- R2: On a rising `tck` with `capture_dr` high and the chain selected (`sel_extest` or `sel_sample` high, `sel_highz` low), each cell loads its observed signal. Input cells load the pad input. A bidirectional pin's enable cell loads `core_oe[j]`, its data cell loads `core_out[j]` and its input cell loads `io_in[j]`.
- R3: On a rising `tck` with `shift_dr` high, `capture_dr` low and the chain selected, cell 0 takes `tdi`, every cell k>0 takes the old value of cell k-1, and `tdo` always shows the last cell.
- R4: The update stage copies the chain only on a falling `tck` with `update_dr` high and the chain selected.
- R5: The capture/shift stage holds its contents on any rising edge that has no capture or shift strobe, or on which the chain is not selected. The update stage holds on any falling edge that fails the R4 condition.
- R6: With `sel_extest` and `sel_highz` both low, `pin_out` equals `core_out` and `pin_oe` equals `core_oe`.
- R7: With `sel_extest` high and `sel_highz` low, `pin_out[j]` is the update data cell of pin j and `pin_oe[j]` is its update enable cell (1 drives the pad).
- R8: With `sel_highz` high, `pin_oe` is all zeros regardless of the other selects, and `pin_out` follows `core_out`.
- R9: Shifting under external test leaves `pin_out` and `pin_oe` unchanged until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_dr | input | 1 | Controller is in the data-capture state |
| shift_dr | input | 1 | Controller is in the data-shift state |
| update_dr | input | 1 | Controller is in the data-update state |
| tdi | input | 1 | Serial data in, next to cell 0 |
| sel_extest | input | 1 | External-test instruction active |
| sel_sample | input | 1 | Sample/preload instruction active |
| sel_highz | input | 1 | Float-all instruction active |
| pin_in | input | N_IN | Input-only pad values |
| io_in | input | N_IO | Bidirectional pad input values |
| core_out | input | N_IO | Core output values |
| core_oe | input | N_IO | Core output enables |
| tdo | output | 1 | Serial data out, last cell |
| pin_out | output | N_IO | Value sent to the pads |
| pin_oe | output | N_IO | Drive enable sent to the pads |

## Verification
A corrupted capture/shift cell can only be seen on `tdo`. It surfaces once the shifts carry that cell to the end of the chain, at most `N_IN + 3*N_IO - 1` rising edges later, so every bit is compared as it leaves. A wrong update cell is invisible while the core owns the pads. It shows on `pin_out`/`pin_oe` within the same half-cycle in which external test is selected. Pins are sampled both before and after each falling edge, so an update that fires on the wrong edge also shows within half a clock.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        PIN_CORE  = 2'd0,
        PIN_TEST  = 2'd1,
        PIN_FLOAT = 2'd2
    } pin_mode_e;

    // first cell of bidirectional pin j: enable, data, input follow
    function automatic int io_base(input int n_in, input int j);
        return n_in + 3 * j;
    endfunction

endpackage

// File: rtl/bscan_shift.sv
module bscan_shift #(
    parameter int LEN = 4
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] chain_q,
    output logic           tdo
);

    typedef struct packed {
        logic [LEN-1:0] cells;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.cells = cap_vec;
        end else if (shift_en) begin
            st_d.cells = {st_q.cells[LEN-2:0], tdi};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_q = st_q.cells;
    assign tdo     = st_q.cells[LEN-1];

    AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !cap_en) |=> (chain_q[0] == $past(tdi))); // R3
    AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !cap_en) |=> (chain_q[LEN-1:1] == $past(chain_q[LEN-2:0]))); // R3
    AST_SHIFT_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (!shift_en && !cap_en) |=> $stable(chain_q)); // R5

endmodule

// File: rtl/bscan_update.sv
module bscan_update #(
    parameter int LEN = 4
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           upd_en,
    input  logic [LEN-1:0] chain_q,
    output logic [LEN-1:0] upd_q
);

    typedef struct packed {
        logic [LEN-1:0] cells;
    } upd_st_t;

    upd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.cells = chain_q;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_q = st_q.cells;

    AST_UPD_HOLD: assert property (@(negedge tck) disable iff (!trst_n)
        !upd_en |=> $stable(upd_q)); // R5
    AST_UPD_COPY: assert property (@(negedge tck) disable iff (!trst_n)
        upd_en |=> (upd_q == $past(chain_q))); // R4

endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux
    import bscan_pkg::*;
#(
    parameter int N_IO = 1
) (
    input  pin_mode_e       mode,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    input  logic [N_IO-1:0] upd_dat,
    input  logic [N_IO-1:0] upd_ena,
    output logic [N_IO-1:0] pin_out,
    output logic [N_IO-1:0] pin_oe
);

    always_comb begin
        unique case (mode)
            PIN_TEST: begin
                pin_out = upd_dat;
                pin_oe  = upd_ena;
            end
            PIN_FLOAT: begin
                pin_out = core_out;
                pin_oe  = '0;
            end
            default: begin
                pin_out = core_out;
                pin_oe  = core_oe;
            end
        endcase
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN = 2,
    parameter int N_IO = 3
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    input  logic            sel_extest,
    input  logic            sel_sample,
    input  logic            sel_highz,
    input  logic [N_IN-1:0] pin_in,
    input  logic [N_IO-1:0] io_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic            tdo,
    output logic [N_IO-1:0] pin_out,
    output logic [N_IO-1:0] pin_oe
);

    localparam int LEN = N_IN + 3 * N_IO;

    logic            chain_sel;
    logic [LEN-1:0]  cap_vec;
    logic [LEN-1:0]  chain_q;
    logic [LEN-1:0]  upd_q;
    logic [N_IO-1:0] upd_dat;
    logic [N_IO-1:0] upd_ena;
    pin_mode_e       mode;

    assign chain_sel = (sel_extest || sel_sample) && !sel_highz;

    for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
        assign cap_vec[i] = pin_in[i];
    end

    for (genvar j = 0; j < N_IO; j++) begin : g_io_cell
        localparam int B = io_base(N_IN, j);
        assign cap_vec[B]     = core_oe[j];
        assign cap_vec[B + 1] = core_out[j];
        assign cap_vec[B + 2] = io_in[j];
        assign upd_ena[j]     = upd_q[B];
        assign upd_dat[j]     = upd_q[B + 1];
    end

    always_comb begin
        if (sel_highz) begin
            mode = PIN_FLOAT;
        end else if (sel_extest) begin
            mode = PIN_TEST;
        end else begin
            mode = PIN_CORE;
        end
    end

    bscan_shift #(.LEN(LEN)) u_shift (
        .tck      (tck),
        .trst_n   (trst_n),
        .cap_en   (capture_dr && chain_sel),
        .shift_en (shift_dr && chain_sel),
        .tdi      (tdi),
        .cap_vec  (cap_vec),
        .chain_q  (chain_q),
        .tdo      (tdo)
    );

    bscan_update #(.LEN(LEN)) u_update (
        .tck     (tck),
        .trst_n  (trst_n),
        .upd_en  (update_dr && chain_sel),
        .chain_q (chain_q),
        .upd_q   (upd_q)
    );

    bscan_pinmux #(.N_IO(N_IO)) u_pinmux (
        .mode     (mode),
        .core_out (core_out),
        .core_oe  (core_oe),
        .upd_dat  (upd_dat),
        .upd_ena  (upd_ena),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    AST_RESET_CLEAR: assert property (@(posedge tck)
        !trst_n |-> (tdo == 1'b0)); // R1
    AST_FLOAT_ALL: assert property (@(posedge tck) disable iff (!trst_n)
        sel_highz |-> (pin_oe == '0)); // R8
    AST_CORE_PASS: assert property (@(posedge tck) disable iff (!trst_n)
        (!sel_extest && !sel_highz) |-> (pin_out == core_out && pin_oe == core_oe)); // R6
    AST_TEST_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
        (sel_extest && !sel_highz && !update_dr && $stable(sel_extest) && $stable(sel_highz))
            |-> ($stable(pin_out) && $stable(pin_oe))); // R9

endmodule

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;

    localparam int N_IN   = 2;
    localparam int N_IO   = 3;
    localparam int LEN    = N_IN + 3 * N_IO;
    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;

    logic            tck = 1'b0;
    logic            trst_n, capture_dr, shift_dr, update_dr, tdi;
    logic            sel_extest, sel_sample, sel_highz;
    logic [N_IN-1:0] pin_in;
    logic [N_IO-1:0] io_in, core_out, core_oe;
    logic            tdo;
    logic [N_IO-1:0] pin_out, pin_oe;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    bit m_sh[$];
    bit m_upd[$];

    always #HALF tck = ~tck;

    bscan_chain #(.N_IN(N_IN), .N_IO(N_IO)) u_bscan_chain (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .sel_extest(sel_extest),
        .sel_sample(sel_sample), .sel_highz(sel_highz), .pin_in(pin_in),
        .io_in(io_in), .core_out(core_out), .core_oe(core_oe), .tdo(tdo),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic bit in_chain();
        return (sel_extest || sel_sample) && !sel_highz;
    endfunction

    task automatic model_reset();
        m_sh.delete();
        m_upd.delete();
        for (int k = 0; k < LEN; k++) begin
            m_sh.push_back(1'b0);
            m_upd.push_back(1'b0);
        end
    endtask

    task automatic model_rise();
        if (!trst_n || !in_chain()) return;
        if (capture_dr) begin
            for (int i = 0; i < N_IN; i++) m_sh[i] = pin_in[i];
            for (int j = 0; j < N_IO; j++) begin
                m_sh[N_IN + 3*j]     = core_oe[j];
                m_sh[N_IN + 3*j + 1] = core_out[j];
                m_sh[N_IN + 3*j + 2] = io_in[j];
            end
        end else if (shift_dr) begin
            m_sh.push_front(tdi);
            void'(m_sh.pop_back());
        end
    endtask

    task automatic model_fall();
        if (trst_n && in_chain() && update_dr) begin
            for (int k = 0; k < LEN; k++) m_upd[k] = m_sh[k];
        end
    endtask

    task automatic compare();
        logic [N_IO-1:0] e_out, e_oe;
        for (int j = 0; j < N_IO; j++) begin
            if (sel_highz) begin
                e_out[j] = core_out[j]; e_oe[j] = 1'b0;
            end else if (sel_extest) begin
                e_out[j] = m_upd[N_IN + 3*j + 1]; e_oe[j] = m_upd[N_IN + 3*j];
            end else begin
                e_out[j] = core_out[j]; e_oe[j] = core_oe[j];
            end
        end
        n_checks++;
        if ({tdo, pin_out, pin_oe} !== {m_sh[LEN-1], e_out, e_oe}) begin
            n_fail++;
            $display("FAIL %s t=%0t tdo/out/oe act=%b/%b/%b exp=%b/%b/%b", cur_req, $time,
                     tdo, pin_out, pin_oe, m_sh[LEN-1], e_out, e_oe);
        end
    endtask

    // called just after a rising edge; returns just after the next one
    task automatic tick(input int n = 1);
        for (int c = 0; c < n; c++) begin
            #(HALF - 2);
            compare();
            @(negedge tck);
            model_fall();
            #(HALF - 1);
            compare();
            @(posedge tck);
            model_rise();
            #1;
        end
    endtask

    task automatic shift_bits(input logic [15:0] pat, input int n);
        shift_dr = 1'b1;
        for (int b = 0; b < n; b++) begin
            tdi = pat[b % 16];
            tick();
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        trst_n = 1'b0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
        sel_extest = 0; sel_sample = 0; sel_highz = 0;
        pin_in = '0; io_in = '0; core_out = '0; core_oe = '0;
        model_reset();
        @(posedge tck); #1;
        cur_req = "R1"; tick(3);
        trst_n = 1'b1;
        sel_extest = 1'b1; core_out = '1; core_oe = '1;
        tick(2);
        sel_extest = 1'b0;

        cur_req = "R6";
        for (int p = 0; p < 6; p++) begin
            core_out = 3'(p * 5 + 1); core_oe = 3'(p * 3 + 2); tick();
        end

        cur_req = "R2";
        sel_sample = 1'b1;
        pin_in = 2'b10; io_in = 3'b011; core_out = 3'b101; core_oe = 3'b110;
        capture_dr = 1'b1; tick(); capture_dr = 1'b0;
        core_out = 3'b000; io_in = 3'b111;
        cur_req = "R3"; shift_bits(16'hA5C3, 5);
        cur_req = "R5"; capture_dr = 0; tick(2);
        sel_sample = 1'b0; shift_dr = 1'b1; tdi = 1'b1; tick(2); shift_dr = 1'b0;
        sel_sample = 1'b1;
        cur_req = "R3"; shift_bits(16'h3C96, LEN - 5);

        cur_req = "R4";
        update_dr = 1'b1; tick(); update_dr = 1'b0;
        tick();

        cur_req = "R7";
        sel_sample = 1'b0; sel_extest = 1'b1; tick(2);
        core_out = 3'b111; core_oe = 3'b000; tick(2);

        cur_req = "R9"; shift_bits(16'h0F5A, LEN);
        cur_req = "R4"; update_dr = 1'b1; tick(); update_dr = 1'b0; tick(2);

        cur_req = "R8";
        sel_highz = 1'b1; core_oe = '1; tick(2);
        sel_extest = 1'b0; tick();
        cur_req = "R5";
        shift_bits(16'hFFFF, 3);
        capture_dr = 1'b1; tick(); capture_dr = 1'b0;
        update_dr = 1'b1; tick(); update_dr = 1'b0;
        sel_highz = 1'b0; sel_extest = 1'b1; tick(2);
        shift_bits(16'h1234, LEN);

        cur_req = "R1";
        trst_n = 1'b0; model_reset(); tick(2);
        trst_n = 1'b1; tick(2);
        sel_extest = 1'b0; tick();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule